// File: doc/BRIEF.md
# Two-Sided Message Mailbox with Coupled Acknowledge

This block connects two software agents, a guest side and a host side, through a pair of one-way message lanes. Each side owns a small register window with a write strobe, a word address and a combinational read-data return. A side composes a message of four 32-bit words (word 0 carries the request or event code, words 1 to 3 carry data), raises its transmit-valid flag, and waits until the peer acknowledges. The peer sees the words and a receive-valid flag, and acknowledges by writing its receive control register.

Each lane is driven by a three-state machine. IDLE means no message is posted, and the sender may edit its words. POSTED means transmit-valid is set and the words are frozen. ACKED means the receiver has acknowledged. The transitions are: IDLE to POSTED when the sender writes 1 to bit 0 of its transmit control; POSTED to ACKED when the receiver writes its receive control with bit 1 set; POSTED or ACKED back to IDLE when the sender writes 0 to bit 0 of its transmit control. Clearing valid releases the acknowledge on both sides in the same edge, so the next send never starts with an old acknowledge. Each side has two level interrupts, one for an incoming message and one for an acknowledge, and each is gated by its own enable bit.

Top module: `mbox_duplex`

Register window per side (word addresses): 0 to 3 are the own transmit words; 4 to 7 are the incoming words (read-only); 8 is transmit control (bit 0 valid, read/write; bit 1 acknowledge, read-only); 9 is receive control (bit 0 receive-valid, read-only; bit 1 receive-acknowledge, set by a write with bit 1 = 1); 10 is interrupt enable (bit 0 message, bit 1 acknowledge). Addresses 11 to 15 read as zero.

## Requirements
- R1: After reset every address of both windows reads zero and all four interrupt outputs are low.
- R2: While a side's transmit-valid is clear, writes to addresses 0 to 3 store the word; the side reads it back at the same address and the peer reads it at that address plus 4.
- R3: Writing address 8 with bit 0 = 1 sets transmit-valid (read at address 8 bit 0), and the peer reads receive-valid as 1 at address 9 bit 0; writing bit 0 = 0 clears both.
- R4: While transmit-valid is set, writes to addresses 0 to 3 are ignored, so both the own readback and the peer view stay unchanged.
- R5: A write to address 9 with bit 1 = 1 while receive-valid is set acknowledges the message: the receiver reads address 9 as 3 and the sender reads address 8 as 3.
- R6: A write to address 9 while receive-valid is clear has no effect; a message posted later still reads as unacknowledged.
- R7: When the sender clears transmit-valid, both the receiver's acknowledge and the sender's acknowledge flag read 0 from the next cycle, also when the receiver acknowledges in the same cycle.
- R8: Address 10 holds the two interrupt enable bits (bit 0 message, bit 1 acknowledge) and reads them back.
- R9: The message interrupt of a side is high exactly when its receive-valid and its enable bit 0 are both set.
- R10: The acknowledge interrupt of a side is high exactly when its transmit-acknowledge and its enable bit 1 are both set.
- R11: Writes to read-only locations (addresses 4 to 7, 11 to 15, and bit 1 of address 8) change nothing.
- R12: The two lanes are independent; both sides may post, acknowledge and clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gst_wen | input | 1 | Guest write strobe |
| gst_addr | input | 4 | Guest word address |
| gst_wdata | input | 32 | Guest write data |
| gst_rdata | output | 32 | Guest read data for gst_addr |
| gst_irq_msg | output | 1 | Guest incoming-message interrupt |
| gst_irq_ack | output | 1 | Guest acknowledge interrupt |
| hst_wen | input | 1 | Host write strobe |
| hst_addr | input | 4 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr |
| hst_irq_msg | output | 1 | Host incoming-message interrupt |
| hst_irq_ack | output | 1 | Host acknowledge interrupt |

## Verification
The assertions assume only that each side presents at most one write per cycle and that its strobe, address and data are stable around the clock edge; they make no assumption about the order in which software uses the handshake, so a receiver may acknowledge with no message posted and a sender may clear valid in the same cycle as the acknowledge. The stimulus mixes directed handshakes with random writes from both sides to any of the sixteen addresses, including unused and read-only ones, driven half a cycle away from the edge. This keeps within those assumptions while reaching every lane state and every collision between the two sides.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MSG_WORDS = 4;
    localparam int WORD_W    = 32;
    localparam int REG_AW    = 4;

    typedef enum logic [1:0] {
        LANE_IDLE   = 2'd0,
        LANE_POSTED = 2'd1,
        LANE_ACKED  = 2'd2
    } lane_state_e;
endpackage

// File: rtl/mbox_lane.sv
// One direction of the mailbox: the sender's frozen words and the
// valid/acknowledge handshake state.
module mbox_lane
    import mbox_pkg::*;
#(
    parameter int WORDS = MSG_WORDS,
    parameter int DW    = WORD_W,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_valid_i,
    input  logic                      clr_valid_i,
    input  logic                      word_we_i,
    input  logic [IW-1:0]             word_idx_i,
    input  logic [DW-1:0]             word_data_i,
    input  logic                      ack_req_i,
    output logic                      valid_o,
    output logic                      ack_o,
    output logic [WORDS-1:0][DW-1:0]  msg_o
);
    lane_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE:   if (set_valid_i) state_d = LANE_POSTED;
            LANE_POSTED: begin
                if (clr_valid_i)    state_d = LANE_IDLE;
                else if (ack_req_i) state_d = LANE_ACKED;
            end
            LANE_ACKED:  if (clr_valid_i) state_d = LANE_IDLE;
            default:     state_d = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        valid_o = 1'b0;
        ack_o   = 1'b0;
        unique case (state_q)
            LANE_IDLE:   ;
            LANE_POSTED: valid_o = 1'b1;
            LANE_ACKED:  begin valid_o = 1'b1; ack_o = 1'b1; end
            default:     ;
        endcase
    end

    // words are editable only while nothing is posted
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                msg_o[w] <= '0;
            else if (word_we_i && (word_idx_i == IW'(w)) && (state_q == LANE_IDLE))
                msg_o[w] <= word_data_i;
        end
    end

    assert_valid_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(set_valid_i));
    assert_msg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(msg_o));
    assert_ack_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(ack_req_i && valid_o));
    assert_no_ack_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_i && !valid_o) |=> !ack_o);
    assert_clear_drops_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_i |=> (!ack_o && !valid_o));
endmodule

// File: rtl/mbox_port.sv
// Register window of one side: decode, read mux and interrupt enables.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int WORDS = MSG_WORDS,
    parameter int DW    = WORD_W,
    parameter int AW    = REG_AW,
    localparam int IW   = $clog2(WORDS),
    localparam int A_TXCTL = 2 * WORDS,
    localparam int A_RXCTL = 2 * WORDS + 1,
    localparam int A_IEN   = 2 * WORDS + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wen_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [DW-1:0]             wdata_i,
    output logic [DW-1:0]             rdata_o,
    output logic                      irq_msg_o,
    output logic                      irq_ack_o,
    input  logic                      tx_valid_i,
    input  logic                      tx_ack_i,
    input  logic [WORDS-1:0][DW-1:0]  tx_msg_i,
    input  logic                      rx_valid_i,
    input  logic [WORDS-1:0][DW-1:0]  rx_msg_i,
    input  logic                      rx_ack_i,
    output logic                      set_valid_o,
    output logic                      clr_valid_o,
    output logic                      word_we_o,
    output logic [IW-1:0]             word_idx_o,
    output logic [DW-1:0]             word_data_o,
    output logic                      ack_req_o
);
    logic [1:0]    ien_q;
    logic [IW-1:0] rx_idx;
    logic          hit_tx, hit_rx, hit_txctl, hit_rxctl, hit_ien;

    assign hit_tx    = addr_i < AW'(WORDS);
    assign hit_rx    = !hit_tx && (addr_i < AW'(2 * WORDS));
    assign hit_txctl = addr_i == AW'(A_TXCTL);
    assign hit_rxctl = addr_i == AW'(A_RXCTL);
    assign hit_ien   = addr_i == AW'(A_IEN);
    assign rx_idx    = IW'(addr_i - AW'(WORDS));

    assign set_valid_o = wen_i && hit_txctl &&  wdata_i[0];
    assign clr_valid_o = wen_i && hit_txctl && !wdata_i[0];
    assign word_we_o   = wen_i && hit_tx;
    assign word_idx_o  = addr_i[IW-1:0];
    assign word_data_o = wdata_i;
    assign ack_req_o   = wen_i && hit_rxctl && wdata_i[1];

    always_ff @(posedge clk) begin
        if (!rst_n)                ien_q <= 2'b00;
        else if (wen_i && hit_ien) ien_q <= wdata_i[1:0];
    end

    always_comb begin
        rdata_o = '0;
        if (hit_tx)         rdata_o = tx_msg_i[addr_i[IW-1:0]];
        else if (hit_rx)    rdata_o = rx_msg_i[rx_idx];
        else if (hit_txctl) rdata_o = DW'({tx_ack_i, tx_valid_i});
        else if (hit_rxctl) rdata_o = DW'({rx_ack_i, rx_valid_i});
        else if (hit_ien)   rdata_o = DW'(ien_q);
    end

    assign irq_msg_o = rx_valid_i & ien_q[0];
    assign irq_ack_o = tx_ack_i & ien_q[1];

    assert_irq_msg_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_o |-> rx_valid_i);
    assert_irq_ack_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> tx_ack_i);
    assert_ien_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_i && hit_ien) |=> $stable(ien_q));
endmodule

// File: rtl/mbox_duplex.sv
// Two-sided mailbox: lane s carries messages sent by side s (0 guest, 1 host).
module mbox_duplex
    import mbox_pkg::*;
#(
    parameter int WORDS = MSG_WORDS,
    parameter int DW    = WORD_W,
    parameter int AW    = REG_AW,
    localparam int IW   = $clog2(WORDS),
    localparam int SIDES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gst_wen,
    input  logic [AW-1:0] gst_addr,
    input  logic [DW-1:0] gst_wdata,
    output logic [DW-1:0] gst_rdata,
    output logic          gst_irq_msg,
    output logic          gst_irq_ack,
    input  logic          hst_wen,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    output logic          hst_irq_msg,
    output logic          hst_irq_ack
);
    logic [SIDES-1:0]                      wen_v, irq_msg_v, irq_ack_v;
    logic [SIDES-1:0][AW-1:0]              addr_v;
    logic [SIDES-1:0][DW-1:0]              wdata_v, rdata_v, wdata_lane;
    logic [SIDES-1:0]                      set_v, clr_v, we_v, ack_req_v, valid_v, ack_v;
    logic [SIDES-1:0][IW-1:0]              idx_v;
    logic [SIDES-1:0][WORDS-1:0][DW-1:0]   msg_v;

    assign wen_v   = {hst_wen, gst_wen};
    assign addr_v  = {hst_addr, gst_addr};
    assign wdata_v = {hst_wdata, gst_wdata};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int P = SIDES - 1 - s;

        mbox_lane #(.WORDS(WORDS), .DW(DW)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_valid_i (set_v[s]),
            .clr_valid_i (clr_v[s]),
            .word_we_i   (we_v[s]),
            .word_idx_i  (idx_v[s]),
            .word_data_i (wdata_lane[s]),
            .ack_req_i   (ack_req_v[P]),
            .valid_o     (valid_v[s]),
            .ack_o       (ack_v[s]),
            .msg_o       (msg_v[s])
        );

        mbox_port #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .wen_i       (wen_v[s]),
            .addr_i      (addr_v[s]),
            .wdata_i     (wdata_v[s]),
            .rdata_o     (rdata_v[s]),
            .irq_msg_o   (irq_msg_v[s]),
            .irq_ack_o   (irq_ack_v[s]),
            .tx_valid_i  (valid_v[s]),
            .tx_ack_i    (ack_v[s]),
            .tx_msg_i    (msg_v[s]),
            .rx_valid_i  (valid_v[P]),
            .rx_msg_i    (msg_v[P]),
            .rx_ack_i    (ack_v[P]),
            .set_valid_o (set_v[s]),
            .clr_valid_o (clr_v[s]),
            .word_we_o   (we_v[s]),
            .word_idx_o  (idx_v[s]),
            .word_data_o (wdata_lane[s]),
            .ack_req_o   (ack_req_v[s])
        );
    end

    assign gst_rdata   = rdata_v[0];
    assign hst_rdata   = rdata_v[1];
    assign gst_irq_msg = irq_msg_v[0];
    assign hst_irq_msg = irq_msg_v[1];
    assign gst_irq_ack = irq_ack_v[0];
    assign hst_irq_ack = irq_ack_v[1];

    // a host-side clear must never disturb the guest-to-host lane
    assert_lanes_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_v[0] && !clr_v[0]) |=> valid_v[0]);
endmodule

// File: tb/sim_mbox_duplex.sv
module sim_mbox_duplex;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gst_wen = 1'b0, hst_wen = 1'b0;
    logic [3:0]  gst_addr = '0, hst_addr = '0;
    logic [31:0] gst_wdata = '0, hst_wdata = '0;
    logic [31:0] gst_rdata, hst_rdata;
    logic        gst_irq_msg, gst_irq_ack, hst_irq_msg, hst_irq_ack;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_tx [2][4];
    bit          m_val [2];
    bit          m_ack [2];
    bit [1:0]    m_ien [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_duplex u0 (
        .clk(clk), .rst_n(rst_n),
        .gst_wen(gst_wen), .gst_addr(gst_addr), .gst_wdata(gst_wdata),
        .gst_rdata(gst_rdata), .gst_irq_msg(gst_irq_msg), .gst_irq_ack(gst_irq_ack),
        .hst_wen(hst_wen), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_irq_msg(hst_irq_msg), .hst_irq_ack(hst_irq_ack)
    );

    function automatic logic [31:0] exp_read(int s, int a);
        int p = 1 - s;
        if (a < 4)       return m_tx[s][a];
        else if (a < 8)  return m_tx[p][a-4];
        else if (a == 8) return {30'd0, m_ack[s], m_val[s]};
        else if (a == 9) return {30'd0, m_ack[p], m_val[p]};
        else if (a == 10) return {30'd0, m_ien[s]};
        return 32'd0;
    endfunction

    function automatic string tag_of(int a);
        if (a < 8)   return "R2";
        if (a == 8)  return "R3";
        if (a == 9)  return "R5";
        if (a == 10) return "R8";
        return "R11";
    endfunction

    task automatic model_step(bit we0, int a0, logic [31:0] d0, bit we1, int a1, logic [31:0] d1);
        bit we[2];
        int ad[2];
        logic [31:0] d[2];
        bit nv[2];
        bit na[2];
        we[0] = we0; we[1] = we1; ad[0] = a0; ad[1] = a1; d[0] = d0; d[1] = d1;
        for (int s = 0; s < 2; s++) begin
            int p = 1 - s;
            nv[s] = m_val[s];
            na[s] = m_ack[s];
            if (we[s] && ad[s] == 8) nv[s] = d[s][0];
            if (we[s] && ad[s] == 8 && !d[s][0]) na[s] = 1'b0;
            else if (we[p] && ad[p] == 9 && d[p][1] && m_val[s]) na[s] = 1'b1;
            if (we[s] && ad[s] < 4 && !m_val[s]) m_tx[s][ad[s]] = d[s];
            if (we[s] && ad[s] == 10) m_ien[s] = d[s][1:0];
        end
        for (int s = 0; s < 2; s++) begin
            m_val[s] = nv[s];
            m_ack[s] = na[s];
        end
    endtask

    task automatic drive(int s, bit we, int a, logic [31:0] d);
        if (s == 0) begin gst_wen = we; gst_addr = a[3:0]; gst_wdata = d; end
        else        begin hst_wen = we; hst_addr = a[3:0]; hst_wdata = d; end
    endtask

    task automatic step(bit we0, int a0, logic [31:0] d0, bit we1, int a1, logic [31:0] d1);
        @(negedge clk);
        drive(0, we0, a0, d0);
        drive(1, we1, a1, d1);
        @(posedge clk);
        model_step(we0, a0, d0, we1, a1, d1);
        @(negedge clk);
        drive(0, 1'b0, 0, 32'd0);
        drive(1, 1'b0, 0, 32'd0);
    endtask

    task automatic chk(int s, int a, string tag);
        logic [31:0] got, exp;
        drive(s, 1'b0, a, 32'd0);
        #1;
        got = (s == 0) ? gst_rdata : hst_rdata;
        exp = exp_read(s, a);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s side=%0d addr=%0d got=%h exp=%h", tag, s, a, got, exp);
        end
    endtask

    task automatic chk_irq(int s, string tag);
        bit g_msg, g_ack, e_msg, e_ack;
        g_msg = (s == 0) ? gst_irq_msg : hst_irq_msg;
        g_ack = (s == 0) ? gst_irq_ack : hst_irq_ack;
        e_msg = m_val[1-s] & m_ien[s][0];
        e_ack = m_ack[s] & m_ien[s][1];
        checks++;
        if (g_msg !== e_msg || g_ack !== e_ack) begin
            bad++;
            $display("FAIL %s side=%0d irq msg/ack got=%b%b exp=%b%b", tag, s, g_msg, g_ack, e_msg, e_ack);
        end
    endtask

    task automatic chk_lit(int s, int a, logic [31:0] exp, string tag);
        logic [31:0] got;
        drive(s, 1'b0, a, 32'd0);
        #1;
        got = (s == 0) ? gst_rdata : hst_rdata;
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s side=%0d addr=%0d got=%h exp=%h", tag, s, a, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 4; w++) m_tx[s][w] = '0;
            m_val[s] = 0; m_ack[s] = 0; m_ien[s] = 2'b00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) chk_lit(s, a, 32'd0, "R1");
            chk_irq(s, "R1");
        end

        // R2: guest composes a message
        for (int w = 0; w < 4; w++) step(1, w, 32'hA5A50000 + w, 0, 0, 0);
        chk_lit(0, 2, 32'hA5A50002, "R2");
        chk_lit(1, 7, 32'hA5A50003, "R2");

        // R8: enable both interrupts on both sides
        step(1, 10, 32'd3, 1, 10, 32'd3);
        chk_lit(0, 10, 32'd3, "R8");
        chk_lit(1, 10, 32'd3, "R8");

        // R3 / R9: post
        step(1, 8, 32'd1, 0, 0, 0);
        chk_lit(0, 8, 32'd1, "R3");
        chk_lit(1, 9, 32'd1, "R3");
        chk_irq(1, "R9");

        // R4: write while posted is ignored
        step(1, 0, 32'hDEADBEEF, 0, 0, 0);
        chk_lit(0, 0, 32'hA5A50000, "R4");
        chk_lit(1, 4, 32'hA5A50000, "R4");

        // R11: read-only targets
        step(1, 8, 32'd3, 1, 5, 32'h12345678);
        chk_lit(0, 8, 32'd1, "R11");
        chk_lit(1, 5, 32'hA5A50001, "R11");
        step(1, 13, 32'hFFFFFFFF, 1, 15, 32'hFFFFFFFF);
        chk_lit(0, 13, 32'd0, "R11");
        chk_lit(1, 15, 32'd0, "R11");

        // R5 / R10: host acknowledges
        step(0, 0, 0, 1, 9, 32'd2);
        chk_lit(0, 8, 32'd3, "R5");
        chk_lit(1, 9, 32'd3, "R5");
        chk_irq(0, "R10");

        // R7: sender clears, acknowledge gone on both sides
        step(1, 8, 32'd0, 0, 0, 0);
        chk_lit(0, 8, 32'd0, "R7");
        chk_lit(1, 9, 32'd0, "R7");
        chk_irq(0, "R10");

        // R6: acknowledge with nothing posted is ignored
        step(0, 0, 0, 1, 9, 32'd2);
        step(1, 8, 32'd1, 0, 0, 0);
        chk_lit(1, 9, 32'd1, "R6");
        chk_lit(0, 8, 32'd1, "R6");

        // R7: clear and acknowledge in the same cycle
        step(1, 8, 32'd0, 1, 9, 32'd2);
        chk_lit(0, 8, 32'd0, "R7");
        chk_lit(1, 9, 32'd0, "R7");

        // R12: both sides post together, then cross-acknowledge together
        step(1, 8, 32'd1, 1, 8, 32'd1);
        step(1, 9, 32'd2, 1, 9, 32'd2);
        chk_lit(0, 8, 32'd3, "R12");
        chk_lit(1, 8, 32'd3, "R12");
        step(0, 0, 0, 1, 8, 32'd0);
        chk_lit(0, 8, 32'd3, "R12");
        chk_lit(0, 9, 32'd0, "R12");

        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            bit we0, we1;
            int a0, a1;
            logic [31:0] d0, d1;
            we0 = ($urandom % 2) == 1;
            we1 = ($urandom % 2) == 1;
            a0 = (($urandom % 4) == 0) ? int'($urandom % 16) : 8 + int'($urandom % 3);
            a1 = (($urandom % 4) == 0) ? int'($urandom % 16) : 8 + int'($urandom % 3);
            if (($urandom % 3) == 0) a0 = int'($urandom % 4);
            if (($urandom % 3) == 0) a1 = int'($urandom % 4);
            d0 = $urandom;
            d1 = $urandom;
            step(we0, a0, d0, we1, a1, d1);
            begin
                int c0, c1;
                c0 = int'($urandom % 16);
                c1 = int'($urandom % 16);
                chk(0, c0, tag_of(c0));
                chk(1, c1, tag_of(c1));
                chk_irq(0, "R9/R10 random");
                chk_irq(1, "R9/R10 random");
            end
        end

        finish_run();
    end
endmodule